// File: doc/BRIEF.md
# Soft-output LLR and extrinsic stage for an 8-state turbo component decoder

This block is the last stage of a soft-in soft-out component decoder for an 8-state recursive systematic convolutional code. For each trellis step it gets the eight forward state metrics of the previous step, the eight backward state metrics of the current step and the four branch metrics. It forms one candidate path metric per trellis branch. It then reduces the eight candidates of each information-bit value to a single metric and takes their difference as the a-posteriori LLR. The extrinsic LLR comes from the same stage: the a-priori, systematic and parity LLRs of the step are subtracted from the a-posteriori value. Both results are saturated before they leave the block.

Each step carries a mode bit that selects the combining operator. With the mode set, the operator is the exact log-sum, computed as a maximum plus a correction read from a small table. With the mode clear, it is the plain maximum of the max-log approximation. The two reductions run side by side in registered binary trees, so the block accepts a new step on every clock. The result appears a fixed number of cycles later, marked by an output valid.

Top module: `mlm_llr_unit`

## Requirements
- R1: State s (bits s[2:0]) with input bit u has a feedback bit f = u^s[1]^s[2], a parity bit p = f^s[0]^s[2] and a next state {s[1],s[0],f}. For each u, candidate s (s = 0..7) is alpha[s] + gamma[2u+p] + beta[next]. out_llr is the reduction of the u=1 candidates minus the reduction of the u=0 candidates.
- R2: With in_mode=1 the operator is max(a,b) + T[d], where d=|a-b|. T is 3,2,2,2,1,1,1 for d = 0 to 6 and 0 for d >= 7. Candidates are combined in the pairs (0,1), (2,3), (4,5), (6,7), then adjacent results in pairs, then the final two.
- R3: With in_mode=0 the operator is the plain maximum, with no correction.
- R4: out_ext is the saturated out_llr minus (in_apr + in_sys + in_par), clipped to ±(2^(EW-1)-1), which is ±127 by default.
- R5: out_llr saturates symmetrically to ±(2^(OW-1)-1), which is ±511 by default.
- R6: A step sampled with in_valid at clock edge k appears with out_valid=1 after edge k+4. Steps may arrive on consecutive cycles, and out_valid is high only for steps that were accepted.
- R7: The mode is sampled with each step and stays with that step. Steps of different modes may alternate cycle by cycle.
- R8: While reset is held, out_valid, out_llr and out_ext are zero.
- R9: out_llr and out_ext keep their last values in cycles where no step completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A trellis step is present |
| in_mode | input | 1 | 1 = corrected log-sum, 0 = plain maximum |
| in_alpha | input | 8*MW | Forward metrics, state s at bits [s*MW +: MW], signed |
| in_beta | input | 8*MW | Backward metrics, state s at bits [s*MW +: MW], signed |
| in_gamma | input | 4*MW | Branch metrics, index 2u+p at bits [(2u+p)*MW +: MW], signed |
| in_apr | input | LW | A-priori LLR, signed |
| in_sys | input | LW | Systematic channel LLR, signed |
| in_par | input | LW | Parity channel LLR, signed |
| out_valid | output | 1 | Result present |
| out_llr | output | OW | A-posteriori LLR, signed, saturated |
| out_ext | output | EW | Extrinsic LLR, signed, clipped |

## Verification
All-equal candidates in both modes separate the two operators most sharply, because the correction then piles up to 9 in each tree and must cancel in the difference. Small random spreads of a few units exercise every table entry and the pairing order. The same inputs are repeated with the mode toggled on each step, which shows whether the mode stays with its step through the pipeline. Large opposing branch metrics with extreme channel LLRs drive both saturation limits. Gapped valid patterns show that the outputs hold their values and that only accepted steps emerge.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
  localparam int NST   = 8;
  localparam int SBITS = 3;

  // Recursive systematic trellis: feedback taps on s[1], s[2]
  function automatic logic fb_bit(input logic [SBITS-1:0] s, input logic u);
    return u ^ s[1] ^ s[2];
  endfunction

  function automatic logic [SBITS-1:0] nxt_state(input logic [SBITS-1:0] s, input logic u);
    return {s[1], s[0], fb_bit(s, u)};
  endfunction

  function automatic logic par_bit(input logic [SBITS-1:0] s, input logic u);
    return fb_bit(s, u) ^ s[0] ^ s[2];
  endfunction

  // ln(1+exp(-d)) in quarter-unit steps, index saturated at 7
  function automatic logic [1:0] corr_lut(input logic [2:0] idx);
    case (idx)
      3'd0:                   return 2'd3;
      3'd1, 3'd2, 3'd3:       return 2'd2;
      3'd4, 3'd5, 3'd6:       return 2'd1;
      default:                return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/mlm_maxstar.sv
module mlm_maxstar import mlm_pkg::*; #(
  parameter int SW = 15
) (
  input  logic signed [SW-1:0] a,
  input  logic signed [SW-1:0] b,
  input  logic                 use_corr,
  output logic signed [SW-1:0] y
);
  logic signed [SW:0]   d;
  logic        [SW:0]   ad;
  logic        [2:0]    idx;
  logic signed [SW-1:0] mx;
  logic signed [SW-1:0] cx;

  always_comb begin
    d   = {a[SW-1], a} - {b[SW-1], b};
    mx  = d[SW] ? b : a;
    ad  = d[SW] ? -d : d;
    idx = (ad >= (SW+1)'(7)) ? 3'd7 : ad[2:0];
    cx  = use_corr ? SW'(corr_lut(idx)) : '0;
    y   = mx + cx;
  end
endmodule

// File: rtl/mlm_cand.sv
module mlm_cand import mlm_pkg::*; #(
  parameter int MW = 12,
  parameter int SW = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [NST*MW-1:0] alpha,
  input  logic [NST*MW-1:0] beta,
  input  logic [4*MW-1:0]   gamma,
  output logic [NST*SW-1:0] cand0,
  output logic [NST*SW-1:0] cand1
);
  logic signed [SW-1:0] cq [2][NST];

  for (genvar u = 0; u < 2; u++) begin : g_bit
    for (genvar s = 0; s < NST; s++) begin : g_st
      localparam logic [SBITS-1:0] NS = nxt_state(3'(s), 1'(u));
      localparam int GI = 2*u + int'(par_bit(3'(s), 1'(u)));
      logic signed [SW-1:0] sum;

      assign sum = SW'($signed(alpha[s*MW +: MW]))
                 + SW'($signed(gamma[GI*MW +: MW]))
                 + SW'($signed(beta[int'(NS)*MW +: MW]));

      always_ff @(posedge clk) begin
        if (rst)           cq[u][s] <= '0;
        else if (in_valid) cq[u][s] <= sum;
      end

      if (u == 0) begin : g_p0
        assign cand0[s*SW +: SW] = cq[u][s];
      end else begin : g_p1
        assign cand1[s*SW +: SW] = cq[u][s];
      end
    end
  end
endmodule

// File: rtl/mlm_tree.sv
module mlm_tree #(
  parameter  int SW = 15,
  parameter  int N  = 8,
  localparam int LV = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LV-1:0]        lvl_vld,
  input  logic [LV-1:0]        lvl_mode,
  input  logic [N*SW-1:0]      leaves,
  output logic signed [SW-1:0] root
);
  logic signed [SW-1:0] lf  [N];
  logic signed [SW-1:0] yw  [LV][N];
  logic signed [SW-1:0] st  [LV][N];

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign lf[j] = $signed(leaves[j*SW +: SW]);
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int W = N >> (l + 1);
    for (genvar j = 0; j < N; j++) begin : g_node
      if (j < W) begin : g_op
        if (l == 0) begin : g_first
          mlm_maxstar #(.SW(SW)) u_op (
            .a(lf[2*j]), .b(lf[2*j+1]), .use_corr(lvl_mode[l]), .y(yw[l][j]));
        end else begin : g_next
          mlm_maxstar #(.SW(SW)) u_op (
            .a(st[l-1][2*j]), .b(st[l-1][2*j+1]), .use_corr(lvl_mode[l]), .y(yw[l][j]));
        end
      end else begin : g_pad
        assign yw[l][j] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LV; l++)
        for (int j = 0; j < N; j++) st[l][j] <= '0;
    end else begin
      for (int l = 0; l < LV; l++)
        if (lvl_vld[l])
          for (int j = 0; j < N; j++) st[l][j] <= yw[l][j];
    end
  end

  assign root = st[LV-1][0];

  AST_STAR_BOUND: assert property (@(posedge clk) disable iff (rst)
    lvl_vld[0] |=> (st[0][0] >= ($past(lf[0]) > $past(lf[1]) ? $past(lf[0]) : $past(lf[1])))
               && (st[0][0] <= ($past(lf[0]) > $past(lf[1]) ? $past(lf[0]) : $past(lf[1])) + 3)); // R2

  AST_MAXLOG_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (lvl_vld[0] && !lvl_mode[0]) |=>
      (st[0][0] == ($past(lf[0]) > $past(lf[1]) ? $past(lf[0]) : $past(lf[1])))); // R3
endmodule

// File: rtl/mlm_out.sv
module mlm_out #(
  parameter int SW  = 15,
  parameter int LSW = 10,
  parameter int OW  = 10,
  parameter int EW  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic signed [SW-1:0]  m1,
  input  logic signed [SW-1:0]  m0,
  input  logic signed [LSW-1:0] lsum,
  output logic                  out_valid,
  output logic [OW-1:0]         out_llr,
  output logic [EW-1:0]         out_ext
);
  localparam int LMAXI = (1 << (OW-1)) - 1;
  localparam int EMAXI = (1 << (EW-1)) - 1;
  localparam int DW    = ((OW > LSW) ? OW : LSW) + 1;

  logic signed [SW:0]   d;
  logic signed [OW-1:0] llr_c;
  logic signed [DW-1:0] e;
  logic signed [EW-1:0] ext_c;

  always_comb begin
    d = (SW+1)'(m1) - (SW+1)'(m0);
    if (d > (SW+1)'(LMAXI))       llr_c = OW'(LMAXI);
    else if (d < (SW+1)'(-LMAXI)) llr_c = OW'(-LMAXI);
    else                          llr_c = OW'(d);
    e = DW'(llr_c) - DW'(lsum);
    if (e > DW'(EMAXI))           ext_c = EW'(EMAXI);
    else if (e < DW'(-EMAXI))     ext_c = EW'(-EMAXI);
    else                          ext_c = EW'(e);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_llr   <= '0;
      out_ext   <= '0;
    end else begin
      out_valid <= in_vld;
      if (in_vld) begin
        out_llr <= llr_c;
        out_ext <= ext_c;
      end
    end
  end

  AST_LLR_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_llr) <= OW'(LMAXI)) && ($signed(out_llr) >= OW'(-LMAXI))); // R5

  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_ext) <= EW'(EMAXI)) && ($signed(out_ext) >= EW'(-EMAXI))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_llr) && $stable(out_ext)); // R9
endmodule

// File: rtl/mlm_llr_unit.sv
module mlm_llr_unit import mlm_pkg::*; #(
  parameter int MW = 12,
  parameter int LW = 8,
  parameter int OW = 10,
  parameter int EW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [NST*MW-1:0] in_alpha,
  input  logic [NST*MW-1:0] in_beta,
  input  logic [4*MW-1:0]   in_gamma,
  input  logic [LW-1:0]     in_apr,
  input  logic [LW-1:0]     in_sys,
  input  logic [LW-1:0]     in_par,
  output logic              out_valid,
  output logic [OW-1:0]     out_llr,
  output logic [EW-1:0]     out_ext
);
  localparam int SW  = MW + 3;
  localparam int LSW = LW + 2;
  localparam int LV  = $clog2(NST);

  logic [NST*SW-1:0]     cand [2];
  logic signed [SW-1:0]  root [2];
  logic [LV:0]           vq;
  logic [LV-1:0]         mq;
  logic signed [LSW-1:0] lq [LV+1];
  logic signed [LSW-1:0] lsum_in;

  assign lsum_in = LSW'($signed(in_apr)) + LSW'($signed(in_sys)) + LSW'($signed(in_par));

  // Step valid, mode and input-LLR sum travel beside the trees
  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= '0;
      mq <= '0;
      for (int i = 0; i <= LV; i++) lq[i] <= '0;
    end else begin
      vq[0] <= in_valid;
      mq[0] <= in_mode;
      for (int i = 1; i <= LV; i++) vq[i] <= vq[i-1];
      for (int i = 1; i < LV; i++)  mq[i] <= mq[i-1];
      if (in_valid) lq[0] <= lsum_in;
      for (int i = 1; i <= LV; i++) if (vq[i-1]) lq[i] <= lq[i-1];
    end
  end

  mlm_cand #(.MW(MW), .SW(SW)) u_cand (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .alpha(in_alpha), .beta(in_beta), .gamma(in_gamma),
    .cand0(cand[0]), .cand1(cand[1]));

  for (genvar u = 0; u < 2; u++) begin : g_tree
    mlm_tree #(.SW(SW), .N(NST)) u_tree (
      .clk(clk), .rst(rst), .lvl_vld(vq[LV-1:0]), .lvl_mode(mq),
      .leaves(cand[u]), .root(root[u]));
  end

  mlm_out #(.SW(SW), .LSW(LSW), .OW(OW), .EW(EW)) u_out (
    .clk(clk), .rst(rst), .in_vld(vq[LV]),
    .m1(root[1]), .m0(root[0]), .lsum(lq[LV]),
    .out_valid(out_valid), .out_llr(out_llr), .out_ext(out_ext));

  AST_STEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> vq[0]); // R6

  AST_VALID_CHAIN: assert property (@(posedge clk) disable iff (rst)
    vq[LV] |=> out_valid); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !vq[LV] |=> !out_valid); // R6
endmodule

// File: tb/mlm_llr_unit_tb.sv
`timescale 1ns/1ps
module mlm_llr_unit_tb;
  localparam int MW = 12, LW = 8, OW = 10, EW = 8, NS = 8, LAT = 4;
  localparam int LMAX = (1 << (OW-1)) - 1;
  localparam int EMAX = (1 << (EW-1)) - 1;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_mode = 1'b0;
  logic [NS*MW-1:0] in_alpha = '0, in_beta = '0;
  logic [4*MW-1:0]  in_gamma = '0;
  logic [LW-1:0]    in_apr = '0, in_sys = '0, in_par = '0;
  logic             out_valid;
  logic [OW-1:0]    out_llr;
  logic [EW-1:0]    out_ext;

  mlm_llr_unit #(.MW(MW), .LW(LW), .OW(OW), .EW(EW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_alpha(in_alpha), .in_beta(in_beta), .in_gamma(in_gamma),
    .in_apr(in_apr), .in_sys(in_sys), .in_par(in_par),
    .out_valid(out_valid), .out_llr(out_llr), .out_ext(out_ext));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int al[NS], be[NS], ga[4];
  int apr_i = 0, sys_i = 0, par_i = 0;
  bit md = 0;
  bit pv[LAT]; int pl[LAT]; int pe[LAT]; string pt[LAT];
  bit ov = 0; int ol = 0; int oe = 0; string ot = "R1";
  int lut[8] = '{3, 2, 2, 2, 1, 1, 1, 0};

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_out(string vtag, string htag);
    chk(vtag, int'(out_valid), int'(ov), "out_valid");
    if (ov) begin
      chk(ot, int'($signed(out_llr)), ol, "out_llr");
      chk("R4", int'($signed(out_ext)), oe, "out_ext");
    end else begin
      chk(htag, int'($signed(out_llr)), ol, "out_llr held");
      chk(htag, int'($signed(out_ext)), oe, "out_ext held");
    end
  endtask

  function automatic int mstar(int a, int b, bit m);
    int mx, d;
    mx = (a > b) ? a : b;
    d  = (a > b) ? a - b : b - a;
    if (!m) return mx;
    return mx + ((d >= 7) ? 0 : lut[d]);
  endfunction

  function automatic int reduce8(int v[NS], bit m);
    int w[NS];
    w = v;
    for (int n = NS; n > 1; n = n / 2)
      for (int j = 0; j < n / 2; j++) w[j] = mstar(w[2*j], w[2*j+1], m);
    return w[0];
  endfunction

  // Reference for one upcoming clock edge
  task automatic model_step(bit v, string tag);
    int c[2][NS];
    int f, p, nx, llr, ext, d;
    bit sat;
    if (pv[LAT-1]) begin ov = 1; ol = pl[LAT-1]; oe = pe[LAT-1]; ot = pt[LAT-1]; end
    else ov = 0;
    for (int i = LAT-1; i > 0; i--) begin
      pv[i] = pv[i-1]; pl[i] = pl[i-1]; pe[i] = pe[i-1]; pt[i] = pt[i-1];
    end
    pv[0] = v;
    if (v) begin
      for (int u = 0; u < 2; u++)
        for (int s = 0; s < NS; s++) begin
          f  = u ^ ((s >> 1) & 1) ^ ((s >> 2) & 1);
          p  = f ^ (s & 1) ^ ((s >> 2) & 1);
          nx = (((s >> 1) & 1) << 2) | ((s & 1) << 1) | f;
          c[u][s] = al[s] + ga[2*u + p] + be[nx];
        end
      d   = reduce8(c[1], md) - reduce8(c[0], md);
      sat = (d > LMAX) || (d < -LMAX);
      llr = (d > LMAX) ? LMAX : (d < -LMAX) ? -LMAX : d;
      ext = llr - (apr_i + sys_i + par_i);
      ext = (ext > EMAX) ? EMAX : (ext < -EMAX) ? -EMAX : ext;
      pl[0] = llr; pe[0] = ext;
      pt[0] = (tag != "") ? tag : (sat ? "R5" : (md ? "R2" : "R1"));
    end
  endtask

  task automatic step(bit v, string tag);
    @(negedge clk);
    compare_out("R6", "R9");
    in_valid = v;
    in_mode  = md;
    for (int s = 0; s < NS; s++) begin
      in_alpha[s*MW +: MW] = MW'(al[s]);
      in_beta[s*MW +: MW]  = MW'(be[s]);
    end
    for (int g = 0; g < 4; g++) in_gamma[g*MW +: MW] = MW'(ga[g]);
    in_apr = LW'(apr_i); in_sys = LW'(sys_i); in_par = LW'(par_i);
    model_step(v, tag);
  endtask

  function automatic int rs(int r);
    return int'($urandom_range(2*r, 0)) - r;
  endfunction

  task automatic fill(int ra, int rg, int rl);
    for (int s = 0; s < NS; s++) begin al[s] = rs(ra); be[s] = rs(ra); end
    for (int g = 0; g < 4; g++) ga[g] = rs(rg);
    apr_i = rs(rl); sys_i = rs(rl); par_i = rs(rl);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < LAT; i++) begin pv[i] = 0; pl[i] = 0; pe[i] = 0; pt[i] = ""; end
    for (int s = 0; s < NS; s++) begin al[s] = 0; be[s] = 0; end
    for (int g = 0; g < 4; g++) ga[g] = 0;
    // R8: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare_out("R8", "R8");
    end
    rst = 1'b0;
    model_step(0, "");

    // R2: ties, correction accumulates equally in both trees
    md = 1; step(1, "R2");
    md = 0; step(1, "R3");
    // R1 / R2: small random spreads, both modes, back to back (R6)
    for (int i = 0; i < 60; i++) begin md = 1; fill(6, 4, 20); step(1, ""); end
    for (int i = 0; i < 40; i++) begin md = 0; fill(6, 4, 20); step(1, ""); end
    // R3: plain maximum where a correction would change the result
    for (int i = 0; i < 30; i++) begin md = 0; fill(3, 2, 5); step(1, "R3"); end
    // R7: same data, mode alternates per step
    for (int i = 0; i < 20; i++) begin
      if (i % 2 == 0) fill(5, 3, 10);
      md = i[0]; step(1, "R7");
    end
    // R5 / R4: saturation and clipping in both directions
    for (int i = 0; i < 8; i++) begin
      fill(50, 0, 0);
      ga[0] = (i % 2) ? 1500 : -1500; ga[1] = ga[0];
      ga[2] = -ga[0];                 ga[3] = ga[2];
      apr_i = (i % 2) ? 127 : -128; sys_i = apr_i; par_i = apr_i;
      md = i[1]; step(1, "");
    end
    // R9: gapped valid, outputs hold between results
    for (int i = 0; i < 60; i++) begin
      md = i[2]; fill(400, 300, 120);
      step((i % 3) == 0, "");
    end
    // R6: long random burst
    for (int i = 0; i < 100; i++) begin md = i[0] ^ i[3]; fill(900, 600, 127); step(1, ""); end
    for (int i = 0; i < LAT + 3; i++) step(0, "");
    finish_run();
  end
endmodule